// File: doc/BRIEF.md
# Paged program counter with return stack

This block produces the 11-bit instruction address for a small 4-bit controller core. An external instruction decoder tells it each cycle what kind of control transfer the current instruction performs. The decoder also presents whatever address bits the opcode carries, and the ROM byte for table-driven jumps. The block then steps, jumps, calls or returns. It keeps three return addresses in a shift-register stack, and raises a skip flag after a return that is meant to skip the next instruction.

Program memory is treated as 32 pages of 64 bytes. A short jump stays inside the page of the following address. The two pages starting at 0x080 form a shared 128-byte region where the short jump reaches across both pages. A short call always lands in the page at 0x080. Long jumps and calls carry a full address. A table-load operation uses the second stack level as scratch storage and overwrites the third.

Every page-relative decision uses the following address (current PC plus one), which is the same value a call pushes.

Top module: `paged_pc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0, `skip` becomes 0 and all three stack levels become 0; a return right after reset therefore yields 0.
- R2: Op code 1 (step) loads `pc` with `pc`+1 modulo 2048, carrying across 64-byte page and 256-byte block boundaries and wrapping 0x7FF to 0x000.
- R3: Op code 2 (short jump), when the following address has bits 10:7 not equal to 0001, loads bits 10:6 of the following address with `near_field[5:0]` below them.
- R4: Op code 2 (short jump), when the following address has bits 10:7 equal to 0001, loads bits 10:7 of the following address with all seven bits of `near_field` below them.
- R5: Op code 3 (page call), outside the shared region pushes the following address and loads 0x080 | `near_field[5:0]`; inside the shared region it acts exactly as the R4 jump and pushes nothing.
- R6: Op code 4 (long jump) loads `far_addr`; op code 5 (long call) loads `far_addr` and pushes the following address. A push moves level 0 to level 1 and level 1 to level 2, and the old level 2 is lost.
- R7: Op code 7 (return) loads `pc` from level 0, moves level 1 to level 0 and level 2 to level 1, and leaves level 2 unchanged.
- R8: Op code 6 (table jump) keeps bits 10:8 of the following address and loads bits 7:0 from `table_byte`.
- R9: Op code 8 (return-and-skip) pops exactly as R7 and drives `skip` high for the one cycle after it. After any other op, `skip` is low.
- R10: Op code 9 (table load) advances `pc` by one and copies level 1 into level 2, leaving levels 0 and 1 unchanged.
- R11: Op code 0 (hold) and the unused codes 10 to 15 change neither `pc` nor the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Decoded control operation for this cycle |
| near_field | input | 7 | Address field of a one-byte jump or call |
| far_addr | input | 11 | Full target of a two-byte jump or call |
| table_byte | input | 8 | ROM byte read for a table jump |
| pc | output | 11 | Current program address |
| skip | output | 1 | High for one cycle after a return-and-skip |

## Verification
The bench aims at the page-edge cases. A short jump placed in the last byte of a page must land in the next page; a design that takes the page from the current address stays behind. A page call issued from inside the shared region must behave as a jump. A design that pushes there shows up when the next return comes back to the wrong place. The bench overflows the stack with four calls and then returns four times. A design that clears or rotates the deepest level returns a wrong address on the fourth pop. A table load between calls must destroy the third level. The bench also checks that `skip` falls after exactly one cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int ADDR_W  = 11;
    localparam int PAGE_W  = 6;
    localparam int BLOCK_W = 8;
    localparam int NEAR_W  = PAGE_W + 1;
    localparam int TBL_W   = BLOCK_W;
    localparam int OP_W    = 4;
    localparam int HI_W    = ADDR_W - PAGE_W;       // page number width
    localparam int REG_W   = ADDR_W - PAGE_W - 1;   // region number width
    localparam int BLK_HI  = ADDR_W - BLOCK_W;

    localparam logic [REG_W-1:0] SHARED_REGION = REG_W'(1);
    localparam logic [HI_W-1:0]  CALL_PAGE     = HI_W'(2);

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_HOLD       = 4'd0,
        OP_STEP       = 4'd1,
        OP_NEAR_JMP   = 4'd2,
        OP_PAGE_CALL  = 4'd3,
        OP_FAR_JMP    = 4'd4,
        OP_FAR_CALL   = 4'd5,
        OP_TABLE_JMP  = 4'd6,
        OP_RET        = 4'd7,
        OP_RET_SKIP   = 4'd8,
        OP_TABLE_LOAD = 4'd9
    } pc_op_e;

    typedef enum logic [1:0] {
        STK_KEEP,
        STK_PUSH,
        STK_POP,
        STK_DUP
    } stk_act_e;

    typedef struct packed {
        addr_t    target;
        stk_act_e act;
        logic     skip;
    } step_plan_t;

    function automatic logic in_shared_region(addr_t a);
        return a[ADDR_W-1:PAGE_W+1] == SHARED_REGION;
    endfunction

    function automatic addr_t near_target(addr_t seq, logic [NEAR_W-1:0] f);
        if (in_shared_region(seq))
            return {seq[ADDR_W-1:PAGE_W+1], f};
        return {seq[ADDR_W-1:PAGE_W], f[PAGE_W-1:0]};
    endfunction

    function automatic addr_t call_target(logic [NEAR_W-1:0] f);
        return {CALL_PAGE, f[PAGE_W-1:0]};
    endfunction

    function automatic addr_t table_target(addr_t seq, logic [TBL_W-1:0] b);
        return {seq[ADDR_W-1:BLOCK_W], b};
    endfunction

endpackage

// File: rtl/pcs_next.sv
module pcs_next
    import pcs_pkg::*;
(
    input  addr_t              pc_q,
    input  logic [OP_W-1:0]    op_code,
    input  logic [NEAR_W-1:0]  near_field,
    input  addr_t              far_addr,
    input  logic [TBL_W-1:0]   table_byte,
    input  addr_t              stk_top,
    output step_plan_t         plan,
    output addr_t              ret_addr
);

    addr_t  seq;
    pc_op_e op;

    always_comb begin
        op       = pc_op_e'(op_code);
        seq      = pc_q + addr_t'(1);
        ret_addr = seq;
        plan     = '{target: pc_q, act: STK_KEEP, skip: 1'b0};
        case (op)
            OP_STEP: begin
                plan.target = seq;
            end
            OP_NEAR_JMP: begin
                plan.target = near_target(seq, near_field);
            end
            OP_PAGE_CALL: begin
                if (in_shared_region(seq)) begin
                    plan.target = near_target(seq, near_field);
                end else begin
                    plan.target = call_target(near_field);
                    plan.act    = STK_PUSH;
                end
            end
            OP_FAR_JMP: begin
                plan.target = far_addr;
            end
            OP_FAR_CALL: begin
                plan.target = far_addr;
                plan.act    = STK_PUSH;
            end
            OP_TABLE_JMP: begin
                plan.target = table_target(seq, table_byte);
            end
            OP_RET: begin
                plan.target = stk_top;
                plan.act    = STK_POP;
            end
            OP_RET_SKIP: begin
                plan.target = stk_top;
                plan.act    = STK_POP;
                plan.skip   = 1'b1;
            end
            OP_TABLE_LOAD: begin
                plan.target = seq;
                plan.act    = STK_DUP;
            end
            default: begin
                plan.target = pc_q;
            end
        endcase
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
    import pcs_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  stk_act_e act,
    input  addr_t    push_val,
    output addr_t    top
);

    localparam int LAST = DEPTH - 1;

    addr_t lvl [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
            addr_t from_above;
            addr_t from_below;
            addr_t dup_val;

            if (i == 0) begin : g_first
                assign from_above = push_val;
            end else begin : g_rest
                assign from_above = lvl[i-1];
            end

            if (i == LAST) begin : g_deepest
                assign from_below = lvl[i];
            end else begin : g_inner
                assign from_below = lvl[i+1];
            end

            if (i == 2) begin : g_scratch
                assign dup_val = lvl[1];
            end else begin : g_plain
                assign dup_val = lvl[i];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl[i] <= '0;
                end else begin
                    case (act)
                        STK_PUSH: lvl[i] <= from_above;
                        STK_POP:  lvl[i] <= from_below;
                        STK_DUP:  lvl[i] <= dup_val;
                        default:  lvl[i] <= lvl[i];
                    endcase
                end
            end
        end
    endgenerate

    assign top = lvl[0];

endmodule

// File: rtl/paged_pc_seq.sv
module paged_pc_seq
    import pcs_pkg::*;
#(
    parameter int STACK_DEPTH = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     op_code,
    input  logic [NEAR_W-1:0]   near_field,
    input  logic [ADDR_W-1:0]   far_addr,
    input  logic [TBL_W-1:0]    table_byte,
    output logic [ADDR_W-1:0]   pc,
    output logic                skip
);

    addr_t      pc_q;
    logic       skip_q;
    step_plan_t plan;
    addr_t      ret_addr;
    addr_t      stk_top;

    pcs_next u_next (
        .pc_q       (pc_q),
        .op_code    (op_code),
        .near_field (near_field),
        .far_addr   (far_addr),
        .table_byte (table_byte),
        .stk_top    (stk_top),
        .plan       (plan),
        .ret_addr   (ret_addr)
    );

    pcs_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .act      (plan.act),
        .push_val (ret_addr),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            skip_q <= 1'b0;
        end else begin
            pc_q   <= plan.target;
            skip_q <= plan.skip;
        end
    end

    assign pc   = pc_q;
    assign skip = skip_q;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_code,
    input logic [ADDR_W-1:0] far_addr,
    input logic [TBL_W-1:0]  table_byte,
    input logic [ADDR_W-1:0] pc,
    input logic              skip
);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && !skip));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_STEP) |=> (pc == addr_t'($past(pc) + addr_t'(1))));

    p_far_jmp_r6: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_FAR_JMP || op_code == OP_FAR_CALL) |=> (pc == $past(far_addr)));

    p_call_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_FAR_CALL) ##1 (op_code == OP_RET) |=>
            (pc == addr_t'($past(pc, 2) + addr_t'(1))));

    p_table_jmp_r8: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_TABLE_JMP) |=> (pc[BLOCK_W-1:0] == $past(table_byte)));

    p_retsk_r9: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_RET_SKIP) |=> skip);

    p_noskip_r9: assert property (@(posedge clk) disable iff (rst)
        (op_code != OP_RET_SKIP) |=> !skip);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_HOLD || op_code > OP_TABLE_LOAD) |=> $stable(pc));

endmodule

bind paged_pc_seq pcs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_code    (op_code),
    .far_addr   (far_addr),
    .table_byte (table_byte),
    .pc         (pc),
    .skip       (skip)
);

// File: tb/sim_paged_pc_seq.sv
module sim_paged_pc_seq;
    import pcs_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [10:0] pc;
        logic        skip;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = '0;
    logic [6:0]  near_field = '0;
    logic [10:0] far_addr = '0;
    logic [7:0]  table_byte = '0;
    logic [10:0] pc;
    logic        skip;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [10:0] m_pc = '0;
    logic [10:0] m_stk [3] = '{default: '0};
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    paged_pc_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .op_code    (op_code),
        .near_field (near_field),
        .far_addr   (far_addr),
        .table_byte (table_byte),
        .pc         (pc),
        .skip       (skip)
    );

    task automatic m_push(input logic [10:0] v);
        m_stk[2] = m_stk[1];
        m_stk[1] = m_stk[0];
        m_stk[0] = v;
    endtask

    task automatic m_pop();
        m_pc     = m_stk[0];
        m_stk[0] = m_stk[1];
        m_stk[1] = m_stk[2];
    endtask

    function automatic logic [10:0] m_near(logic [10:0] s, logic [6:0] f);
        if (s[10:7] == 4'b0001) return {s[10:7], f};
        return {s[10:6], f[5:0]};
    endfunction

    // Driver: apply one operation, predict the result, queue it.
    task automatic drive(input logic [3:0] op, input logic [6:0] nf,
                         input logic [10:0] fa, input logic [7:0] tb,
                         input string tag);
        logic [10:0] s;
        logic        sk;
        @(negedge clk);
        rst = 1'b0;
        op_code = op; near_field = nf; far_addr = fa; table_byte = tb;
        s  = m_pc + 11'd1;
        sk = 1'b0;
        case (op)
            OP_STEP:       m_pc = s;
            OP_NEAR_JMP:   m_pc = m_near(s, nf);
            OP_PAGE_CALL: begin
                if (s[10:7] == 4'b0001) m_pc = m_near(s, nf);
                else begin m_push(s); m_pc = {5'b00010, nf[5:0]}; end
            end
            OP_FAR_JMP:    m_pc = fa;
            OP_FAR_CALL:   begin m_push(s); m_pc = fa; end
            OP_TABLE_JMP:  m_pc = {s[10:8], tb};
            OP_RET:        m_pop();
            OP_RET_SKIP:   begin m_pop(); sk = 1'b1; end
            OP_TABLE_LOAD: begin m_stk[2] = m_stk[1]; m_pc = s; end
            default: ;
        endcase
        sb.push_back('{m_pc, sk, tag});
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        op_code = OP_HOLD;
        m_pc = '0;
        m_stk = '{default: '0};
        sb.push_back('{11'd0, 1'b0, tag});
    endtask

    // Monitor: compare one queued expectation per clock.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            tests++;
            if (pc !== e.pc || skip !== e.skip) begin
                fails++;
                $display("FAIL %s: pc=%h skip=%b, expected pc=%h skip=%b",
                         e.tag, pc, skip, e.pc, e.skip);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        do_reset("R1 reset state");
        // R2 sequential stepping and carries
        drive(OP_STEP, 0, 0, 0, "R2 step from 0");
        drive(OP_STEP, 0, 0, 0, "R2 step again");
        drive(OP_FAR_JMP, 0, 11'h03E, 0, "R6 long jump");
        drive(OP_STEP, 0, 0, 0, "R2 step to page end");
        drive(OP_STEP, 0, 0, 0, "R2 page carry");
        drive(OP_FAR_JMP, 0, 11'h0FF, 0, "R6 long jump");
        drive(OP_STEP, 0, 0, 0, "R2 block carry");
        drive(OP_FAR_JMP, 0, 11'h7FF, 0, "R6 long jump top");
        drive(OP_STEP, 0, 0, 0, "R2 wrap to zero");
        // R11 hold and unused codes
        drive(OP_FAR_JMP, 0, 11'h2AA, 0, "R6 long jump");
        drive(OP_HOLD, 7'h3F, 11'h111, 8'hFF, "R11 hold");
        drive(4'd15, 7'h3F, 11'h111, 8'hFF, "R11 unused code 15");
        drive(4'd10, 7'h3F, 11'h111, 8'hFF, "R11 unused code 10");
        // R3 short jump outside the shared region
        drive(OP_FAR_JMP, 0, 11'h1C5, 0, "R6 long jump");
        drive(OP_NEAR_JMP, 7'h5A, 0, 0, "R3 in-page jump");
        drive(OP_FAR_JMP, 0, 11'h13F, 0, "R6 long jump");
        drive(OP_NEAR_JMP, 7'h05, 0, 0, "R3 jump from last page byte");
        // R4 short jump inside the shared region
        drive(OP_FAR_JMP, 0, 11'h0A0, 0, "R6 long jump");
        drive(OP_NEAR_JMP, 7'h70, 0, 0, "R4 region jump up");
        drive(OP_FAR_JMP, 0, 11'h0C3, 0, "R6 long jump");
        drive(OP_NEAR_JMP, 7'h12, 0, 0, "R4 region jump down");
        // R5 page call
        drive(OP_FAR_JMP, 0, 11'h205, 0, "R6 long jump");
        drive(OP_PAGE_CALL, 7'h2B, 0, 0, "R5 page call");
        drive(OP_RET, 0, 0, 0, "R7 return from page call");
        drive(OP_FAR_JMP, 0, 11'h0B0, 0, "R6 long jump");
        drive(OP_PAGE_CALL, 7'h31, 0, 0, "R5 call in region acts as jump");
        drive(OP_RET, 0, 0, 0, "R5 nothing was pushed");
        // R6/R7 stack overflow and pops
        drive(OP_FAR_JMP, 0, 11'h310, 0, "R6 long jump");
        drive(OP_FAR_CALL, 0, 11'h500, 0, "R6 call 1");
        drive(OP_FAR_CALL, 0, 11'h600, 0, "R6 call 2");
        drive(OP_FAR_CALL, 0, 11'h700, 0, "R6 call 3");
        drive(OP_FAR_CALL, 0, 11'h123, 0, "R6 call 4 drops oldest");
        drive(OP_RET, 0, 0, 0, "R7 pop 1");
        drive(OP_RET, 0, 0, 0, "R7 pop 2");
        drive(OP_RET, 0, 0, 0, "R7 pop 3");
        drive(OP_RET, 0, 0, 0, "R7 deepest level retained");
        // R9 return-and-skip
        drive(OP_RET_SKIP, 0, 0, 0, "R9 return and skip");
        drive(OP_STEP, 0, 0, 0, "R9 skip lasts one cycle");
        // R8 table jump
        drive(OP_FAR_JMP, 0, 11'h345, 0, "R6 long jump");
        drive(OP_TABLE_JMP, 0, 0, 8'hC7, "R8 table jump");
        drive(OP_FAR_JMP, 0, 11'h4FF, 0, "R6 long jump");
        drive(OP_TABLE_JMP, 0, 0, 8'h10, "R8 table jump block of next");
        // R10 table load overwrites the third level
        drive(OP_FAR_JMP, 0, 11'h010, 0, "R6 long jump");
        drive(OP_FAR_CALL, 0, 11'h020, 0, "R6 call a");
        drive(OP_FAR_CALL, 0, 11'h030, 0, "R6 call b");
        drive(OP_FAR_CALL, 0, 11'h040, 0, "R6 call c");
        drive(OP_TABLE_LOAD, 0, 0, 0, "R10 table load steps");
        drive(OP_RET, 0, 0, 0, "R10 pop level 0");
        drive(OP_RET, 0, 0, 0, "R10 pop level 1");
        drive(OP_RET, 0, 0, 0, "R10 level 2 was overwritten");
        // R1 reset clears the stack
        drive(OP_FAR_CALL, 0, 11'h3AB, 0, "R6 call before reset");
        do_reset("R1 reset mid-run");
        drive(OP_RET, 0, 0, 0, "R1 stack cleared by reset");
        drive(OP_HOLD, 0, 0, 0, "R11 hold after return");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): run still active, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule